// File: doc/BRIEF.md
# SDRAM Bank State and Precharge Recovery Tracker

This block sits beside a DDR2-style memory command path and follows every decoded command: ACTIVATE, READ, WRITE and PRECHARGE. A precharge carries a flag that selects one bank or every bank. A READ or WRITE can carry an auto-precharge flag. Each command names a bank. For each of eight banks the block keeps an open/idle state and a recovery countdown. From these it reports which banks are open, which are idle and which may be activated now.

Some commands break the bank rules: an ACTIVATE to a bank that is open or still recovering, or a READ or WRITE to an idle bank. The block flags such a command with a one-cycle violation pulse and a reason code, and it leaves the bank state unchanged. There are two recovery intervals, given in clock cycles on static configuration inputs. A single-bank close uses the short one. A close of all banks uses the long one on every bank, whether or not that bank was open. The block also outputs the write latency, computed from the configured CAS and additive latencies.

Top module: `bank_state_tracker`

## Requirements
- R1: After reset every bank is idle and ready, no bank is open, and the violation pulse is low with code 0.
- R2: An ACTIVATE (op code 1) to a ready bank sets that bank's open bit in the cycle after the command.
- R3: An ACTIVATE to a bank that is already open gives a violation with code 1 and leaves all bank state unchanged.
- R4: An ACTIVATE to an idle bank whose recovery has not finished gives a violation with code 2 and leaves all bank state unchanged.
- R5: A READ (op 2) or WRITE (op 3) to an idle bank gives a violation with code 3 and changes no bank state, even when its auto-precharge flag is set.
- R6: A PRECHARGE (op 4) with the all-banks flag low closes only the addressed bank. An ACTIVATE to that bank is accepted when issued cfg_trp cycles after the precharge, and is rejected with code 2 when issued one cycle earlier.
- R7: A PRECHARGE with the all-banks flag high closes every bank and ignores the bank address. Every bank then accepts an ACTIVATE cfg_trpa cycles after the precharge and not before, however many banks were open.
- R8: A READ or WRITE with auto-precharge to an open bank closes that bank in the cycle after the command and starts its cfg_trp recovery. Without the flag the bank stays open.
- R9: The violation pulse is high for exactly the one cycle after an offending command. In every other cycle it is low and the code is 0.
- R10: wr_latency equals cfg_al + cfg_cl - 1 without waiting for a clock edge, and 0 when both are 0 (for example CL 3, AL 0 gives 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_op | input | 3 | 0 none, 1 ACTIVATE, 2 READ, 3 WRITE, 4 PRECHARGE |
| cmd_bank | input | 3 | Target bank |
| cmd_pre_all | input | 1 | On PRECHARGE: 1 closes all banks, 0 closes one |
| cmd_auto_pre | input | 1 | On READ/WRITE: close the bank after the access |
| cfg_trp | input | 8 | Single-bank recovery in cycles (at least 1) |
| cfg_trpa | input | 8 | All-bank recovery in cycles (at least cfg_trp) |
| cfg_cl | input | 4 | CAS latency |
| cfg_al | input | 4 | Additive latency |
| bank_open | output | 8 | Per-bank open row flag |
| bank_idle | output | 8 | Per-bank idle flag |
| bank_ready | output | 8 | Per-bank idle with recovery finished |
| viol_pulse | output | 1 | One-cycle rule violation flag |
| viol_code | output | 2 | 1 activate open, 2 activate recovering, 3 access idle |
| wr_latency | output | 5 | Computed write latency |

## Verification
All bank flags and the violation pulse are registered. They change on the clock edge that samples the command, so each result is due one cycle after the command is presented. Recovery boundaries follow from that: an ACTIVATE issued N cycles after a precharge is sampled N edges later. The bench drives each command at the falling edge. The driver queues the expected result for that command, and a monitor compares it 5 ns after the next rising edge, so each item is checked in exactly the cycle it is due. The write latency is combinational and is checked 1 ns after the configuration changes.

// File: rtl/bst_pkg.sv
package bst_pkg;

    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_ACT  = 3'd1,
        OP_RD   = 3'd2,
        OP_WR   = 3'd3,
        OP_PRE  = 3'd4
    } bst_op_e;

    typedef enum logic [1:0] {
        VC_NONE     = 2'd0,
        VC_ACT_OPEN = 2'd1,
        VC_ACT_BUSY = 2'd2,
        VC_RW_IDLE  = 2'd3
    } bst_vcode_e;

    typedef struct packed {
        logic       hit;
        bst_vcode_e code;
    } bst_viol_t;

endpackage

// File: rtl/bst_cmd_decode.sv
module bst_cmd_decode
    import bst_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    localparam int BA_W = $clog2(NUM_BANKS)
) (
    input  logic                 cmd_valid,
    input  logic [2:0]           cmd_op,
    input  logic [BA_W-1:0]      cmd_bank,
    input  logic                 cmd_pre_all,
    input  logic                 cmd_auto_pre,
    input  logic [NUM_BANKS-1:0] cur_open,
    input  logic [NUM_BANKS-1:0] cur_ready,
    output logic [NUM_BANKS-1:0] act_mask,
    output logic [NUM_BANKS-1:0] pre_mask,
    output logic                 pre_long,
    output bst_viol_t            viol
);

    logic [NUM_BANKS-1:0] sel;
    bst_op_e              op;

    always_comb begin
        op       = bst_op_e'(cmd_op);
        sel      = NUM_BANKS'(1) << cmd_bank;
        act_mask = '0;
        pre_mask = '0;
        pre_long = 1'b0;
        viol     = '{hit: 1'b0, code: VC_NONE};
        if (cmd_valid) begin
            unique case (op)
                OP_ACT: begin
                    if (cur_open[cmd_bank]) begin
                        viol = '{hit: 1'b1, code: VC_ACT_OPEN};
                    end else if (!cur_ready[cmd_bank]) begin
                        viol = '{hit: 1'b1, code: VC_ACT_BUSY};
                    end else begin
                        act_mask = sel;
                    end
                end
                OP_RD, OP_WR: begin
                    if (!cur_open[cmd_bank]) begin
                        viol = '{hit: 1'b1, code: VC_RW_IDLE};
                    end else if (cmd_auto_pre) begin
                        pre_mask = sel;
                    end
                end
                OP_PRE: begin
                    if (cmd_pre_all) begin
                        pre_mask = '1;
                        pre_long = 1'b1;
                    end else begin
                        pre_mask = sel;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/bst_bank.sv
module bst_bank #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_go,
    input  logic             pre_go,
    input  logic             pre_long,
    input  logic [CNT_W-1:0] cfg_trp,
    input  logic [CNT_W-1:0] cfg_trpa,
    output logic             is_open,
    output logic             is_idle,
    output logic             is_ready
);

    typedef struct packed {
        logic             open;
        logic [CNT_W-1:0] cnt;
    } bank_st_t;

    bank_st_t         st_d, st_q;
    logic [CNT_W-1:0] load_val;

    always_comb begin
        load_val = pre_long ? cfg_trpa : cfg_trp;
        // the edge that samples the command counts as the first recovery cycle
        if (load_val != '0) begin
            load_val = load_val - 1'b1;
        end
        st_d = st_q;
        if (act_go) begin
            st_d.open = 1'b1;
        end else if (pre_go) begin
            st_d.open = 1'b0;
            st_d.cnt  = load_val;
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{open: 1'b0, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign is_open  = st_q.open;
    assign is_idle  = !st_q.open;
    assign is_ready = !st_q.open && (st_q.cnt == '0);

endmodule

// File: rtl/bst_wl_calc.sv
module bst_wl_calc #(
    parameter int LAT_W = 4
) (
    input  logic [LAT_W-1:0] cl,
    input  logic [LAT_W-1:0] al,
    output logic [LAT_W:0]   wl
);

    logic [LAT_W:0] sum;

    always_comb begin
        sum = {1'b0, cl} + {1'b0, al};
        wl  = (sum == '0) ? '0 : sum - 1'b1;
    end

endmodule

// File: rtl/bank_state_tracker.sv
module bank_state_tracker
    import bst_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int CNT_W     = 8,
    parameter int LAT_W     = 4,
    localparam int BA_W     = $clog2(NUM_BANKS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    input  logic [2:0]           cmd_op,
    input  logic [BA_W-1:0]      cmd_bank,
    input  logic                 cmd_pre_all,
    input  logic                 cmd_auto_pre,
    input  logic [CNT_W-1:0]     cfg_trp,
    input  logic [CNT_W-1:0]     cfg_trpa,
    input  logic [LAT_W-1:0]     cfg_cl,
    input  logic [LAT_W-1:0]     cfg_al,
    output logic [NUM_BANKS-1:0] bank_open,
    output logic [NUM_BANKS-1:0] bank_idle,
    output logic [NUM_BANKS-1:0] bank_ready,
    output logic                 viol_pulse,
    output logic [1:0]           viol_code,
    output logic [LAT_W:0]       wr_latency
);

    logic [NUM_BANKS-1:0] act_mask;
    logic [NUM_BANKS-1:0] pre_mask;
    logic                 pre_long;
    bst_viol_t            viol_now;
    bst_viol_t            viol_d, viol_q;

    bst_cmd_decode #(.NUM_BANKS(NUM_BANKS)) u_dec (
        .cmd_valid    (cmd_valid),
        .cmd_op       (cmd_op),
        .cmd_bank     (cmd_bank),
        .cmd_pre_all  (cmd_pre_all),
        .cmd_auto_pre (cmd_auto_pre),
        .cur_open     (bank_open),
        .cur_ready    (bank_ready),
        .act_mask     (act_mask),
        .pre_mask     (pre_mask),
        .pre_long     (pre_long),
        .viol         (viol_now)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        bst_bank #(.CNT_W(CNT_W)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .act_go   (act_mask[b]),
            .pre_go   (pre_mask[b]),
            .pre_long (pre_long),
            .cfg_trp  (cfg_trp),
            .cfg_trpa (cfg_trpa),
            .is_open  (bank_open[b]),
            .is_idle  (bank_idle[b]),
            .is_ready (bank_ready[b])
        );
    end

    always_comb begin
        viol_d = viol_now;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            viol_q <= '{hit: 1'b0, code: VC_NONE};
        end else begin
            viol_q <= viol_d;
        end
    end

    assign viol_pulse = viol_q.hit;
    assign viol_code  = viol_q.code;

    bst_wl_calc #(.LAT_W(LAT_W)) u_wl (
        .cl (cfg_cl),
        .al (cfg_al),
        .wl (wr_latency)
    );

endmodule

// File: rtl/bst_checker.sv
module bst_checker #(
    parameter int NUM_BANKS = 8,
    parameter int CNT_W     = 8,
    localparam int BA_W     = $clog2(NUM_BANKS)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cmd_valid,
    input logic [2:0]           cmd_op,
    input logic [BA_W-1:0]      cmd_bank,
    input logic                 cmd_pre_all,
    input logic [CNT_W-1:0]     cfg_trpa,
    input logic [NUM_BANKS-1:0] bank_open,
    input logic [NUM_BANKS-1:0] bank_ready,
    input logic                 viol_pulse,
    input logic [1:0]           viol_code
);

    p_act_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd1 && bank_ready[cmd_bank])
        |=> bank_open[$past(cmd_bank)]);

    p_act_reject_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd1 && bank_open[cmd_bank])
        |=> (viol_pulse && viol_code == 2'd1 && bank_open == $past(bank_open)));

    p_act_busy_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd1 && !bank_open[cmd_bank] && !bank_ready[cmd_bank])
        |=> (viol_pulse && viol_code == 2'd2 && bank_open == $past(bank_open)));

    p_rw_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (cmd_op == 3'd2 || cmd_op == 3'd3) && !bank_open[cmd_bank])
        |=> (viol_pulse && viol_code == 2'd3 && bank_open == $past(bank_open)));

    p_pre_all_closes_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd4 && cmd_pre_all && cfg_trpa > CNT_W'(1))
        |=> (bank_open == '0 && bank_ready == '0));

    p_pulse_needs_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cmd_valid) |-> (!viol_pulse && viol_code == 2'd0));

endmodule

bind bank_state_tracker bst_checker #(.NUM_BANKS(NUM_BANKS), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_op      (cmd_op),
    .cmd_bank    (cmd_bank),
    .cmd_pre_all (cmd_pre_all),
    .cfg_trpa    (cfg_trpa),
    .bank_open   (bank_open),
    .bank_ready  (bank_ready),
    .viol_pulse  (viol_pulse),
    .viol_code   (viol_code)
);

// File: tb/bank_state_tracker_tb.sv
`timescale 1ns/1ps
module bank_state_tracker_tb;

    localparam logic [2:0] OP_ACT = 3'd1;
    localparam logic [2:0] OP_RD  = 3'd2;
    localparam logic [2:0] OP_WR  = 3'd3;
    localparam logic [2:0] OP_PRE = 3'd4;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cmd_valid;
    logic [2:0] cmd_op;
    logic [2:0] cmd_bank;
    logic       cmd_pre_all;
    logic       cmd_auto_pre;
    logic [7:0] cfg_trp;
    logic [7:0] cfg_trpa;
    logic [3:0] cfg_cl;
    logic [3:0] cfg_al;
    logic [7:0] bank_open;
    logic [7:0] bank_idle;
    logic [7:0] bank_ready;
    logic       viol_pulse;
    logic [1:0] viol_code;
    logic [4:0] wr_latency;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;
    logic [7:0] model_open = 8'h00;

    typedef struct {
        string      req;
        logic       ev;
        logic [1:0] ec;
        logic [7:0] eo;
        logic [7:0] rm;
        logic [7:0] er;
    } exp_t;

    exp_t exp_q[$];

    always #10 clk = ~clk;

    bank_state_tracker u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_valid    (cmd_valid),
        .cmd_op       (cmd_op),
        .cmd_bank     (cmd_bank),
        .cmd_pre_all  (cmd_pre_all),
        .cmd_auto_pre (cmd_auto_pre),
        .cfg_trp      (cfg_trp),
        .cfg_trpa     (cfg_trpa),
        .cfg_cl       (cfg_cl),
        .cfg_al       (cfg_al),
        .bank_open    (bank_open),
        .bank_idle    (bank_idle),
        .bank_ready   (bank_ready),
        .viol_pulse   (viol_pulse),
        .viol_code    (viol_code),
        .wr_latency   (wr_latency)
    );

    // monitor: results are due just after the edge that samples the command
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_checks++;
                if (viol_pulse !== e.ev || viol_code !== e.ec || bank_open !== e.eo ||
                    (bank_ready & e.rm) !== (e.er & e.rm)) begin
                    n_fails++;
                    $display("FAIL %s: viol=%b code=%0d open=%h ready=%h, expected viol=%b code=%0d open=%h ready&%h=%h",
                             e.req, viol_pulse, viol_code, bank_open, bank_ready,
                             e.ev, e.ec, e.eo, e.rm, e.er & e.rm);
                end
            end
        end
    end

    task automatic send(input logic [2:0] op, input int bank, input logic all_b,
                        input logic ap, input string req, input logic ev,
                        input logic [1:0] ec, input logic [7:0] eo,
                        input logic [7:0] rm, input logic [7:0] er);
        exp_t e;
        cmd_valid    = 1'b1;
        cmd_op       = op;
        cmd_bank     = 3'(bank);
        cmd_pre_all  = all_b;
        cmd_auto_pre = ap;
        e = '{req: req, ev: ev, ec: ec, eo: eo, rm: rm, er: er};
        exp_q.push_back(e);
        model_open = eo;
        @(negedge clk);
        cmd_valid    = 1'b0;
        cmd_op       = 3'd0;
        cmd_pre_all  = 1'b0;
        cmd_auto_pre = 1'b0;
    endtask

    task automatic idle(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            exp_t e;
            e = '{req: req, ev: 1'b0, ec: 2'd0, eo: model_open, rm: 8'h00, er: 8'h00};
            exp_q.push_back(e);
            @(negedge clk);
        end
    endtask

    task automatic check_wl(input logic [3:0] cl, input logic [3:0] al, input logic [4:0] exp_wl);
        cfg_cl = cl;
        cfg_al = al;
        #1;
        n_checks++;
        if (wr_latency !== exp_wl) begin
            n_fails++;
            $display("FAIL R10: wr_latency=%0d expected %0d (cl=%0d al=%0d)", wr_latency, exp_wl, cl, al);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        rst_n        = 1'b0;
        cmd_valid    = 1'b0;
        cmd_op       = 3'd0;
        cmd_bank     = 3'd0;
        cmd_pre_all  = 1'b0;
        cmd_auto_pre = 1'b0;
        cfg_trp      = 8'd3;
        cfg_trpa     = 8'd5;
        cfg_cl       = 4'd3;
        cfg_al       = 4'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        n_checks++;
        if (bank_open !== 8'h00 || bank_idle !== 8'hFF || bank_ready !== 8'hFF ||
            viol_pulse !== 1'b0 || viol_code !== 2'd0) begin
            n_fails++;
            $display("FAIL R1: open=%h idle=%h ready=%h viol=%b code=%0d, expected 00 ff ff 0 0",
                     bank_open, bank_idle, bank_ready, viol_pulse, viol_code);
        end

        // R10 write latency
        check_wl(4'd3, 4'd0, 5'd2);
        check_wl(4'd5, 4'd2, 5'd6);
        check_wl(4'd0, 4'd0, 5'd0);
        check_wl(4'd3, 4'd0, 5'd2);
        @(negedge clk);

        // R2 activate ready banks
        send(OP_ACT, 0, 1'b0, 1'b0, "R2", 1'b0, 2'd0, 8'h01, 8'h01, 8'h00);
        send(OP_ACT, 5, 1'b0, 1'b0, "R2", 1'b0, 2'd0, 8'h21, 8'h21, 8'h00);
        // R3 activate open bank
        send(OP_ACT, 0, 1'b0, 1'b0, "R3", 1'b1, 2'd1, 8'h21, 8'h00, 8'h00);
        // R8 read without flag keeps open, write with flag closes
        send(OP_RD,  5, 1'b0, 1'b0, "R8", 1'b0, 2'd0, 8'h21, 8'h00, 8'h00);
        send(OP_WR,  5, 1'b0, 1'b1, "R8", 1'b0, 2'd0, 8'h01, 8'h20, 8'h00);
        // R4 recovering bank rejected at 1 and 2 cycles, accepted at tRP (R8 timing)
        send(OP_ACT, 5, 1'b0, 1'b0, "R4", 1'b1, 2'd2, 8'h01, 8'h20, 8'h00);
        send(OP_ACT, 5, 1'b0, 1'b0, "R4", 1'b1, 2'd2, 8'h01, 8'h20, 8'h20);
        send(OP_ACT, 5, 1'b0, 1'b0, "R8", 1'b0, 2'd0, 8'h21, 8'h00, 8'h00);
        // R6 single-bank precharge of bank 0; bank 5 untouched
        send(OP_PRE, 0, 1'b0, 1'b0, "R6", 1'b0, 2'd0, 8'h20, 8'h01, 8'h00);
        idle(1, "R6");
        send(OP_ACT, 0, 1'b0, 1'b0, "R6", 1'b1, 2'd2, 8'h20, 8'h00, 8'h00);
        send(OP_ACT, 0, 1'b0, 1'b0, "R6", 1'b0, 2'd0, 8'h21, 8'h00, 8'h00);
        // R5 access to idle banks, auto-precharge flag ignored
        send(OP_RD,  3, 1'b0, 1'b1, "R5", 1'b1, 2'd3, 8'h21, 8'h08, 8'h08);
        send(OP_WR,  2, 1'b0, 1'b0, "R5", 1'b1, 2'd3, 8'h21, 8'h04, 8'h04);
        // R9 pulse drops after one cycle
        idle(1, "R9");
        // R7 all-bank precharge, address 6 ignored
        send(OP_PRE, 6, 1'b1, 1'b0, "R7", 1'b0, 2'd0, 8'h00, 8'hFF, 8'h00);
        idle(3, "R7");
        send(OP_ACT, 3, 1'b0, 1'b0, "R7", 1'b1, 2'd2, 8'h00, 8'hFF, 8'hFF);
        send(OP_ACT, 3, 1'b0, 1'b0, "R7", 1'b0, 2'd0, 8'h08, 8'hFF, 8'hF7);
        // R7 long interval applies to banks that were never open
        send(OP_PRE, 0, 1'b1, 1'b0, "R7", 1'b0, 2'd0, 8'h00, 8'hFF, 8'h00);
        idle(3, "R7");
        send(OP_ACT, 1, 1'b0, 1'b0, "R7", 1'b1, 2'd2, 8'h00, 8'h02, 8'h02);
        send(OP_ACT, 1, 1'b0, 1'b0, "R7", 1'b0, 2'd0, 8'h02, 8'hFD, 8'hFD);
        idle(1, "R9");

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule